// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date as eight packed-BCD bytes, advanced from a 32.768 kHz tick enable that arrives in the system clock domain. A fractional prescaler turns the tick into a 100 Hz step. Each step advances a carry chain of fields: hundredths of a second, seconds, minutes, 24-hour hours, day of week, day of month, month, year and a two-bit century count. The day-of-month limit follows the month and whether the year is a leap year.

Bus logic writes any byte through a one-cycle parallel load port, addressed by byte index. Any load also restarts the prescaler, so a newly written time begins a full hundredth-of-a-second interval. A halt bit in the seconds byte freezes the time base until it is cleared again. All eight bytes are presented as live outputs.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the bytes read: hundredths 00, seconds 00, minutes 00, hours 00, weekday 01, day 01, month 01, year 00.
- R2: The prescaler advances the hundredths on average once per 327.68 ticks. After a load, the first advance comes on tick 328, and exactly 32768 ticks produce exactly 100 advances.
- R3: Hundredths count 00 to 99 in BCD and wrap to 00 with a carry into seconds. Seconds (byte 1, bits 6:0) count 00 to 59 and wrap with a carry into minutes.
- R4: Minutes (byte 2) wrap 59 to 00 and carry into hours. Hours (byte 3, bits 5:0) wrap 23 to 00 and carry into the day of month and the weekday. The century bits of the hours byte are kept across the hour wrap.
- R5: In months 04, 06, 09 and 11 the day wraps from 30 to 01. In the other months except 02 it wraps from 31 to 01. On each wrap the month advances.
- R6: In month 02 the day wraps after 29 when the BCD year is divisible by four (including 00), and after 28 otherwise.
- R7: The month wraps 12 to 01 and advances the year. The year wraps 99 to 00 and increments the century field (hours byte bits 7:6) modulo 4.
- R8: The weekday (byte 4, bits 2:0; bits 7:3 read 0) counts 1 to 7, wraps to 1, and advances at the same midnight carry as the day of month.
- R9: While bit 7 of the seconds byte is 1, no byte changes on ticks. Writing it back to 0 resumes counting with a full 328-tick first interval.
- R10: A write to address 0 to 7 replaces that byte at the next clock edge, with unused bits read as 0. The write also restarts the prescaler, so ticks counted before the write do not count toward the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en_i | input | 1 | Load strobe for one byte |
| wr_addr_i | input | 3 | Byte index 0 to 7 of the load |
| wr_data_i | input | 8 | Load data |
| hund_o | output | 8 | Hundredths/tenths of a second, BCD |
| sec_o | output | 8 | Halt bit 7, seconds BCD in bits 6:0 |
| min_o | output | 8 | Minutes BCD |
| hour_o | output | 8 | Century bits 7:6, hours BCD in bits 5:0 |
| wday_o | output | 8 | Weekday 1 to 7 in bits 2:0 |
| mday_o | output | 8 | Day of month BCD |
| month_o | output | 8 | Month BCD |
| year_o | output | 8 | Year BCD |

## Verification
A drifting prescaler accumulator shows up at the hundredths byte within one 328-tick interval. It also shows as a second that does not land on exactly 32768 ticks. A wrong carry limit or a wrong leap decision is only seen at the single step where a field should wrap. So each test loads a value one hundredth of a second before a boundary, and the whole date is visible two cycles after the 328th tick. A stuck halt or a prescaler that is not restarted shows as a hundredths byte that changes one interval too early or too late.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef logic [7:0] bcd8_t;

   localparam int NFLD = 7;

   // two-digit packed BCD increment, no wrap check
   function automatic bcd8_t bcd_inc(bcd8_t v);
      bcd8_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // year 00..99 divisible by four, decided on the BCD digits
   function automatic logic bcd_leap(bcd8_t yr);
      logic [3:0] u;
      u = yr[3:0];
      if (yr[4]) return (u == 4'd2) || (u == 4'd6);
      else       return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
   endfunction

   // last day of a month, BCD
   function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
      bcd8_t r;
      case (mon)
         8'h02:                      r = bcd_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICK_HZ = 32768,
   parameter int STEP_HZ = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic clear_i,
   output logic step_o
);
   localparam int ACC_W   = $clog2(TICK_HZ) + 1;
   localparam int MIN_GAP = TICK_HZ / STEP_HZ;
   localparam int GAP_W   = $clog2(MIN_GAP + 2) + 1;
   localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP_HZ);
   localparam logic [ACC_W-1:0] LIM_V  = ACC_W'(TICK_HZ);

   initial begin
      assert (STEP_HZ > 0 && STEP_HZ < TICK_HZ)
         else $error("rtc_prescaler: STEP_HZ must lie in 1..TICK_HZ-1");
   end

   logic [ACC_W-1:0] acc_q, sum;
   logic             ovf, step_q;

   assign sum = acc_q + STEP_V;
   assign ovf = (sum >= LIM_V);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) begin
         acc_q  <= '0;
         step_q <= 1'b0;
      end else if (tick_i) begin
         acc_q  <= ovf ? sum - LIM_V : sum;
         step_q <= ovf;
      end else begin
         step_q <= 1'b0;
      end
   end

   assign step_o = step_q;

   // tick count since the last step, kept for the rate checks only
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) gap_q <= '0;
      else if (tick_i)        gap_q <= ovf ? '0 : gap_q + 1'b1;
   end

   // R2
   step_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !clear_i && ovf) |-> (gap_q >= GAP_W'(MIN_GAP - 1) && gap_q <= GAP_W'(MIN_GAP)));
   // R2
   no_early_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !clear_i && !ovf) |-> (gap_q < GAP_W'(MIN_GAP)));
   // R10
   clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> !step_o);

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter bcd8_t RST_VAL   = 8'h00,
   parameter bcd8_t FLOOR_VAL = 8'h00
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  adv_i,
   input  logic  ld_i,
   input  bcd8_t ld_val_i,
   input  bcd8_t ceil_i,
   output bcd8_t val_o,
   output logic  wrap_o
);
   bcd8_t val_q;

   assign wrap_o = adv_i && (val_q == ceil_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)    val_q <= RST_VAL;
      else if (ld_i)  val_q <= ld_val_i;
      else if (adv_i) val_q <= wrap_o ? FLOOR_VAL : bcd_inc(val_q);
   end

   assign val_o = val_q;

   // R3
   field_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_o && !ld_i) |=> (val_o == FLOOR_VAL));
   // R10
   field_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |=> (val_o == $past(ld_val_i)));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int TICK_HZ = 32768,
   parameter int STEP_HZ = 100
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       wr_en_i,
   input  logic [2:0] wr_addr_i,
   input  logic [7:0] wr_data_i,
   output logic [7:0] hund_o,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] mday_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o
);
   // field order in the carry chain: hund, sec, min, hour, mday, month, year
   localparam logic [NFLD-1:0][7:0] F_RST   = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
   localparam logic [NFLD-1:0][7:0] F_FLOOR = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
   localparam logic [NFLD-1:0][7:0] F_CEIL  = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h99};
   localparam logic [NFLD-1:0][7:0] F_MASK  = {8'hFF, 8'h1F, 8'h3F, 8'h3F, 8'h7F, 8'h7F, 8'hFF};
   localparam logic [NFLD-1:0][2:0] F_ADDR  = {3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0};
   localparam int I_HOUR = 3;
   localparam int I_MDAY = 4;
   localparam int I_YEAR = 6;
   localparam logic [2:0] A_SEC  = 3'd1;
   localparam logic [2:0] A_HOUR = 3'd3;
   localparam logic [2:0] A_WDAY = 3'd4;

   logic       halt_q;
   logic [1:0] cent_q;
   logic [2:0] wday_q;
   logic       step, adv_base;

   bcd8_t           fld  [NFLD];
   logic [NFLD-1:0] adv, wrap;
   bcd8_t           mday_ceil;

   rtc_prescaler #(.TICK_HZ(TICK_HZ), .STEP_HZ(STEP_HZ)) presc_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .clear_i (wr_en_i || halt_q),
      .step_o  (step)
   );

   assign adv_base  = step && !wr_en_i && !halt_q;
   assign mday_ceil = month_last(fld[I_YEAR-1], fld[I_YEAR]);

   for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
      if (gi == 0) begin : g_head
         assign adv[gi] = adv_base;
      end else begin : g_link
         assign adv[gi] = wrap[gi-1];
      end

      rtc_bcd_field #(.RST_VAL(F_RST[gi]), .FLOOR_VAL(F_FLOOR[gi])) fld_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .adv_i    (adv[gi]),
         .ld_i     (wr_en_i && (wr_addr_i == F_ADDR[gi])),
         .ld_val_i (wr_data_i & F_MASK[gi]),
         .ceil_i   ((gi == I_MDAY) ? mday_ceil : F_CEIL[gi]),
         .val_o    (fld[gi]),
         .wrap_o   (wrap[gi])
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         halt_q <= 1'b0;
         cent_q <= 2'd0;
         wday_q <= 3'd1;
      end else begin
         if (wr_en_i && wr_addr_i == A_SEC)  halt_q <= wr_data_i[7];
         if (wr_en_i && wr_addr_i == A_HOUR) cent_q <= wr_data_i[7:6];
         else if (wrap[I_YEAR])              cent_q <= cent_q + 2'd1;
         if (wr_en_i && wr_addr_i == A_WDAY) wday_q <= wr_data_i[2:0];
         else if (wrap[I_HOUR])              wday_q <= (wday_q >= 3'd7) ? 3'd1 : wday_q + 3'd1;
      end
   end

   assign hund_o  = fld[0];
   assign sec_o   = {halt_q, fld[1][6:0]};
   assign min_o   = {1'b0, fld[2][6:0]};
   assign hour_o  = {cent_q, fld[I_HOUR][5:0]};
   assign wday_o  = {5'd0, wday_q};
   assign mday_o  = fld[I_MDAY];
   assign month_o = fld[I_YEAR-1];
   assign year_o  = fld[I_YEAR];

   // R7
   century_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap[I_YEAR] |=> (hour_o[7:6] == $past(hour_o[7:6]) + 2'd1));
   // R8
   wday_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap[I_HOUR] |=> (wday_o != $past(wday_o)));
   // R9
   halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sec_o[7] && !wr_en_i) |=> ($stable(hund_o) && $stable(sec_o) && $stable(mday_o)));
   // R4
   hour_keeps_century_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap[I_HOUR] && !wrap[I_YEAR]) |=> (hour_o == {$past(hour_o[7:6]), 6'h00}));

endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] hund, sec, mins, hour, wday, mday, month, year;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bcd_rtc_core dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .hund_o(hund), .sec_o(sec), .min_o(mins), .hour_o(hour),
      .wday_o(wday), .mday_o(mday), .month_o(month), .year_o(year)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic load_all(input logic [7:0] h, s, m, hr, wd, md, mo, yr);
      wr(3'd0, h);  wr(3'd1, s);  wr(3'd2, m);  wr(3'd3, hr);
      wr(3'd4, wd); wr(3'd5, md); wr(3'd6, mo); wr(3'd7, yr);
   endtask

   // one hundredth before midnight, then one full interval
   task automatic midnight(input logic [7:0] hr, wd, md, mo, yr);
      load_all(8'h99, 8'h59, 8'h59, hr, wd, md, mo, yr);
      run_ticks(328);
   endtask

   task automatic t_reset;
      chk("R1 hund", hund, 8'h00);  chk("R1 sec", sec, 8'h00);
      chk("R1 min", mins, 8'h00);   chk("R1 hour", hour, 8'h00);
      chk("R1 wday", wday, 8'h01);  chk("R1 mday", mday, 8'h01);
      chk("R1 month", month, 8'h01); chk("R1 year", year, 8'h00);
   endtask

   task automatic t_rate;
      load_all(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      run_ticks(327);
      chk("R2 no step at 327", hund, 8'h00);
      run_ticks(1);
      chk("R2 step at 328", hund, 8'h01);
      wr(3'd0, 8'h00);
      run_ticks(32767);
      chk("R2 99 steps in 32767", hund, 8'h99);
      chk("R2 sec before", sec, 8'h00);
      run_ticks(1);
      chk("R3 hund wraps", hund, 8'h00);
      chk("R3 sec carry", sec, 8'h01);
   endtask

   task automatic t_carry;
      load_all(8'h99, 8'h59, 8'h41, 8'h05, 8'h02, 8'h10, 8'h03, 8'h50);
      run_ticks(328);
      chk("R3 sec wraps", sec, 8'h00);
      chk("R4 min carry", mins, 8'h42);
      midnight(8'h63, 8'h03, 8'h10, 8'h03, 8'h50);
      chk("R4 hour wraps keep century", hour, 8'h40);
      chk("R4 mday carry", mday, 8'h11);
      chk("R8 wday advances", wday, 8'h04);
   endtask

   task automatic t_months;
      midnight(8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
      chk("R5 april 30 wraps", mday, 8'h01);
      chk("R5 month carry", month, 8'h05);
      midnight(8'h23, 8'h01, 8'h30, 8'h05, 8'h21);
      chk("R5 may has 31", mday, 8'h31);
      midnight(8'h23, 8'h01, 8'h30, 8'h11, 8'h21);
      chk("R5 nov 30 wraps", mday, 8'h01);
   endtask

   task automatic t_feb;
      midnight(8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
      chk("R6 leap 24 has 29", mday, 8'h29);
      midnight(8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
      chk("R6 leap 29 wraps", mday, 8'h01);
      chk("R6 march", month, 8'h03);
      midnight(8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      chk("R6 non-leap 28 wraps", mday, 8'h01);
      midnight(8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
      chk("R6 year 00 leap", mday, 8'h29);
      midnight(8'h23, 8'h01, 8'h28, 8'h02, 8'h18);
      chk("R6 year 18 non-leap", mday, 8'h01);
   endtask

   task automatic t_year;
      midnight(8'hA3, 8'h07, 8'h31, 8'h12, 8'h99);
      chk("R7 year wraps", year, 8'h00);
      chk("R7 month wraps", month, 8'h01);
      chk("R7 century +1", hour, 8'hC0);
      chk("R8 wday 7 to 1", wday, 8'h01);
      chk("R4 min wraps", mins, 8'h00);
      midnight(8'hE3, 8'h05, 8'h31, 8'h12, 8'h99);
      chk("R7 century mod 4", hour, 8'h00);
      midnight(8'h23, 8'h01, 8'h31, 8'h12, 8'h41);
      chk("R7 year carry", year, 8'h42);
   endtask

   task automatic t_halt;
      load_all(8'h20, 8'h90, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      run_ticks(1000);
      chk("R9 halted hund", hund, 8'h20);
      chk("R9 halted sec", sec, 8'h90);
      wr(3'd1, 8'h10);
      run_ticks(327);
      chk("R9 resume full interval", hund, 8'h20);
      run_ticks(1);
      chk("R9 resumed", hund, 8'h21);
      chk("R9 sec kept", sec, 8'h10);
   endtask

   task automatic t_load;
      wr(3'd4, 8'hFF);
      chk("R8 wday mask", wday, 8'h07);
      wr(3'd2, 8'hD9);
      chk("R10 min mask", mins, 8'h59);
      wr(3'd0, 8'h10);
      run_ticks(200);
      wr(3'd0, 8'h50);
      run_ticks(200);
      chk("R10 prescaler restarted", hund, 8'h50);
      run_ticks(128);
      chk("R10 step after full interval", hund, 8'h51);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_rate;
      t_carry;
      t_months;
      t_feb;
      t_year;
      t_halt;
      t_load;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule